// File: doc/BRIEF.md
# Repeated-Sample Hold Detector

This block is a clocked synchronous Moore machine with two serial inputs, `a` and `b`, and one output, `z`. The output rises when the value sampled on `a` at one clock edge equals the value sampled on `a` at the edge before it. After that, `z` stays high through every later edge at which `b` is sampled high, even if `a` stops repeating. If `b` is sampled low at an edge where `a` also changed, `z` falls. It then stays low until `a` repeats again.

The state is three bits. A run bit is low only in the initial state. A flag bit says whether the output condition holds. A history bit keeps the last value of `a`. A synchronous reset, active high, puts the machine in the initial state. The first edge after reset only captures `a`, so `z` can rise no earlier than the second edge after reset. The output is the run bit ANDed with the flag bit. Any encoding with the run bit low is treated as the initial state: its output is 0, and its next state is always a legal running state.

Top module: `repeat_hold_fsm`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `z` is 0 after that edge.
- R2: At the first rising edge after reset is released, only `a` is captured. `z` is 0 after that edge for any `a` and `b`.
- R3: At any later edge, if `a` equals the value of `a` sampled at the previous edge, `z` is 1 after that edge. This holds for a repeated 0 and for a repeated 1.
- R4: If `z` is 1 and `b` is 1 at an edge, `z` is 1 after that edge, whatever `a` is.
- R5: If `a` differs from its previous sample and `b` is 0 at an edge, `z` is 0 after that edge.
- R6: Once `z` has fallen, `b` returning to 1 does not raise `z` again. Only a new repeat on `a` does.
- R7: Reset has priority over all transitions. With `rst` high, `z` is 0 after the edge even when `a` repeats and `b` is 1.
- R8: `z` depends on state only. Changes on `a` and `b` between edges leave `z` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 1 | Serial input checked for repeated values |
| b | input | 1 | Serial input that keeps the output high |
| z | output | 1 | Moore output |

## Verification
The assertions check on every cycle that reset clears the output and overrides a live repeat. They also check that the first edge after reset cannot raise `z`, that a repeat on `a` always sets `z`, that `b` high keeps a set output high, and that a change on `a` with `b` low clears it. The bench scenarios show the rest. Only they can show that a fallen output does not come back when `b` alone returns high. Only they can show that input changes between edges do not reach `z`. They also run a long sequence against an independent reference model.

// File: rtl/repeat_hold_pkg.sv
package repeat_hold_pkg;

  // Phase of the control: the initial state or running.
  typedef enum logic {
    PH_INIT = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clearAll;   // synchronous reset of history and flag
    logic captureA;   // store the current a sample as history
    logic evalPair;   // update the output flag from a/b this edge
  } ctrlStrobe_t;

endpackage

// File: rtl/repeat_hold_ctrl.sv
module repeat_hold_ctrl
  import repeat_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output ctrlStrobe_t strobe,
  output logic        running
);

  phase_t phase;
  phase_t phaseNext;

  always_comb begin
    phaseNext = rst ? PH_INIT : PH_RUN;
  end

  always_ff @(posedge clk) begin
    phase <= phaseNext;
  end

  always_comb begin
    strobe.clearAll = rst;
    strobe.captureA = !rst;
    // In the initial state (and any encoding with run low) the flag is
    // reloaded as 0, which also scrubs stray values.
    strobe.evalPair = !rst && (phase == PH_RUN);
  end

  assign running = (phase == PH_RUN);

endmodule

// File: rtl/repeat_hold_dp.sv
module repeat_hold_dp
  import repeat_hold_pkg::*;
(
  input  logic        clk,
  input  ctrlStrobe_t strobe,
  input  logic        a,
  input  logic        b,
  output logic        histA,
  output logic        okFlag
);

  logic pairEq;
  logic okNext;

  assign pairEq = (a == histA);

  always_comb begin
    if (strobe.clearAll)      okNext = 1'b0;
    else if (strobe.evalPair) okNext = pairEq | (okFlag & b);
    else                      okNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    okFlag <= okNext;
    if (strobe.clearAll)      histA <= 1'b0;
    else if (strobe.captureA) histA <= a;
  end

endmodule

// File: rtl/repeat_hold_fsm.sv
module repeat_hold_fsm
  import repeat_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  output logic z
);

  ctrlStrobe_t strobe;
  logic        running;
  logic        histA;
  logic        okFlag;

  repeat_hold_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .running (running)
  );

  repeat_hold_dp u_dp (
    .clk    (clk),
    .strobe (strobe),
    .a      (a),
    .b      (b),
    .histA  (histA),
    .okFlag (okFlag)
  );

  // Output decoded from state only; run bit low forces 0.
  assign z = running & okFlag;

endmodule

// File: rtl/repeat_hold_chk.sv
module repeat_hold_chk (
  input logic clk,
  input logic rst,
  input logic a,
  input logic b,
  input logic z
);

  // Edges since reset release, saturating at 2.
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst)              seen <= 2'd0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !z);

  a_r7_reset_priority: assert property (@(posedge clk)
    (rst && b && seen != 2'd0) |=> !z);

  a_r2_first_edge_quiet: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd0) |=> !z);

  a_r3_repeat_sets: assert property (@(posedge clk) disable iff (rst)
    (seen != 2'd0 && a == $past(a)) |=> z);

  a_r4_b_holds: assert property (@(posedge clk) disable iff (rst)
    (seen != 2'd0 && z && b) |=> z);

  a_r5_change_clears: assert property (@(posedge clk) disable iff (rst)
    (seen != 2'd0 && a != $past(a) && !b) |=> !z);

endmodule

bind repeat_hold_fsm repeat_hold_chk u_chk (
  .clk (clk),
  .rst (rst),
  .a   (a),
  .b   (b),
  .z   (z)
);

// File: tb/repeat_hold_fsm_bench.sv
`timescale 1ns/1ps
module repeat_hold_fsm_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a   = 1'b0;
  logic b   = 1'b0;
  logic z;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  repeat_hold_fsm u_repeat_hold_fsm (
    .clk (clk),
    .rst (rst),
    .a   (a),
    .b   (b),
    .z   (z)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: z=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, then sample 1 ns after the rising edge.
  task automatic tick(input logic r, input logic av, input logic bv);
    @(negedge clk);
    rst = r; a = av; b = bv;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b1);
  endtask

  task automatic tReset();
    doReset();
    check("R1 reset state", z, 1'b0);
  endtask

  task automatic tFirstEdge();
    doReset();
    tick(1'b0, 1'b1, 1'b1);
    check("R2 first edge captures only", z, 1'b0);
    tick(1'b0, 1'b0, 1'b1);
    check("R2 no pair yet", z, 1'b0);
  endtask

  task automatic tRepeat();
    doReset();
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    check("R3 repeated 0", z, 1'b1);
    tick(1'b0, 1'b1, 1'b0);
    check("R5 change with b low", z, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    check("R3 repeated 1", z, 1'b1);
  endtask

  task automatic tHold();
    doReset();
    tick(1'b0, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    check("R3 set before hold", z, 1'b1);
    tick(1'b0, 1'b0, 1'b1);
    check("R4 held by b", z, 1'b1);
    tick(1'b0, 1'b1, 1'b1);
    check("R4 still held", z, 1'b1);
    tick(1'b0, 1'b0, 1'b0);
    check("R5 release", z, 1'b0);
  endtask

  task automatic tNoRecover();
    doReset();
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    check("R5 fall", z, 1'b0);
    tick(1'b0, 1'b0, 1'b1);
    check("R6 b alone no recover", z, 1'b0);
    tick(1'b0, 1'b1, 1'b1);
    check("R6 still low", z, 1'b0);
  endtask

  task automatic tResetPriority();
    doReset();
    tick(1'b0, 1'b1, 1'b1);
    tick(1'b0, 1'b1, 1'b1);
    check("R7 setup", z, 1'b1);
    tick(1'b1, 1'b1, 1'b1);
    check("R7 reset beats repeat", z, 1'b0);
    tick(1'b0, 1'b1, 1'b1);
    check("R7 R2 after reset", z, 1'b0);
  endtask

  task automatic tMoore();
    doReset();
    tick(1'b0, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    a = 1'b0; b = 1'b0;
    #1;
    check("R8 mid-cycle change ignored", z, 1'b1);
    a = 1'b1;
    #0.5;
    check("R8 stable until edge", z, 1'b1);
  endtask

  task automatic tRandom();
    logic mInit, mHist, mOk, av, bv;
    doReset();
    mInit = 1'b1; mHist = 1'b0; mOk = 1'b0;
    for (int i = 0; i < 400; i++) begin
      av = 1'($urandom_range(0, 1));
      bv = 1'($urandom_range(0, 3) != 0);
      tick(1'b0, av, bv);
      if (mInit) mOk = 1'b0;
      else       mOk = (av == mHist) | (mOk & bv);
      mHist = av; mInit = 1'b0;
      check("R3 R4 R5 model", z, mOk);
    end
  endtask

  initial begin
    #50000;
    failures++;
    $display("FAIL watchdog: z=%b expected finish", z);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tReset();
    tFirstEdge();
    tRepeat();
    tHold();
    tNoRecover();
    tResetPriority();
    tMoore();
    tRandom();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule